// File: doc/BRIEF.md
# Configurable-Mode Serial Peripheral Master

This block is a single-lane, full-duplex serial peripheral master. A one-cycle start request carries a transmit word together with the transfer settings. The block then asserts its chip select and runs the serial clock for the chosen number of bits. On each clock it shifts one bit out on MOSI and takes one bit in from MISO. At the end it releases the chip select, presents the received word and raises a one-cycle completion pulse.

The transfer settings are sampled only on the cycle the start is accepted. They are the clock polarity and phase (a 2-bit mode), the word length (4 to 32 bits), the bit order, the chip select polarity, the serial clock half-period in system clocks, and two idle gaps. One gap sits between chip select assertion and the first clock edge. The other sits between the last clock edge and chip select release. A new word can be started on the same cycle the completion pulse is seen, which gives back-to-back words with a single idle clock on the chip select.

Top module: `spi_word_master`

## Requirements
- R1: `spiMode[1]` is the clock polarity and `spiMode[0]` is the phase. While no transfer is running, `sclk` follows `spiMode[1]` with one clock of delay.
- R2: With phase 0, the first data bit is on `mosi` before the first `sclk` edge. The master samples `miso` on leading edges and changes `mosi` only on trailing edges.
- R3: With phase 1, the master changes `mosi` on leading edges (after the first) and samples `miso` on trailing edges.
- R4: A transfer makes exactly 2×`wordLen` `sclk` edges and moves `wordLen` bits in each direction. The received word is right-justified and the bits above `wordLen` are zero.
- R5: With `lsbFirst`=0, `txWord[wordLen-1]` is sent first and the first received bit lands in `rxWord[wordLen-1]`. With `lsbFirst`=1, bit 0 goes first in both directions.
- R6: The active chip select level is 1 when `csActiveHigh`=1 and 0 otherwise. `csOut` holds the active level for the whole transfer and sits at the inactive level when idle.
- R7: The first `sclk` edge comes (`leadHalves`+1)×`halfPeriod` clocks after `csOut` turns active.
- R8: `csOut` turns inactive (`trailHalves`+1)×`halfPeriod` clocks after the last `sclk` edge.
- R9: `done` is a one-cycle pulse in the cycle `csOut` turns inactive. `rxWord` changes only then. `busy` is high from the accepting edge until that cycle.
- R10: A `start` that arrives while `busy` is high is ignored. The running word completes unchanged and no extra transfer follows.
- R11: A `start` given in the cycle `done` is high is accepted, and `csOut` is inactive for exactly one clock between the two words.
- R12: During reset, `sclk`=0, `csOut`=1, `busy`=0, `done`=0 and `rxWord`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| txWord | input | MAX_BITS | Word to transmit, right-justified |
| wordLen | input | LEN_W | Bits per word, 4..MAX_BITS |
| spiMode | input | 2 | {polarity, phase} |
| lsbFirst | input | 1 | 1: least significant bit first |
| csActiveHigh | input | 1 | 1: chip select active high |
| leadHalves | input | GAP_W | Extra half-periods before first edge |
| trailHalves | input | GAP_W | Extra half-periods after last edge |
| halfPeriod | input | DIV_W | System clocks per serial half-period, at least 1 |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| csOut | output | 1 | Chip select |
| rxWord | output | MAX_BITS | Received word |
| done | output | 1 | Transfer complete pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The checker assumes a few things about the inputs. `halfPeriod` is at least 1 and `wordLen` is between 4 and `MAX_BITS` whenever `start` is accepted. `miso` is settled at every system clock edge. The idle-level properties compare `sclk` and `csOut` with the previous cycle's `spiMode` and `csActiveHigh`, so they rely on those inputs reaching the outputs through one register.

The bench drives all settings and `miso` only on falling system clock edges. It changes `miso` only after a launch edge of `sclk`, at least one system edge before the next capture edge. It keeps every length, gap and half-period inside the legal ranges.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } xferState_t;

  // Strobes from the sequencer to the shift datapath.
  typedef struct packed {
    logic idle;     // no transfer running
    logic load;     // start accepted this cycle
    logic toggle;   // serial clock edge this cycle
    logic shift;    // advance the transmit bit
    logic capture;  // sample the input line
    logic finish;   // release chip select, publish result
  } spiStrobe_t;

endpackage

// File: rtl/spi_edge_ctrl.sv
module spi_edge_ctrl
  import spi_master_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int DIV_W = 8,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cpha,
  input  logic [LEN_W-1:0] wordLen,
  input  logic [GAP_W-1:0] leadHalves,
  input  logic [GAP_W-1:0] trailHalves,
  input  logic [DIV_W-1:0] halfPeriod,
  output spiStrobe_t       stb,
  output logic             busy
);

  localparam int CNT_W = LEN_W + 1;

  xferState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] hpLat;
  logic [GAP_W-1:0] gapLeft;
  logic [GAP_W-1:0] trailLat;
  logic [CNT_W-1:0] edgeCnt;
  logic [LEN_W-1:0] lenLat;
  logic             phaseLat;

  logic tick;
  logic leadingEdge;
  logic firstEdge;
  logic lastEdge;
  logic inShift;

  always_comb begin
    tick        = (state != ST_IDLE) && (divCnt == hpLat - DIV_W'(1));
    inShift     = (state == ST_SHIFT);
    leadingEdge = ~edgeCnt[0];
    firstEdge   = (edgeCnt == '0);
    lastEdge    = (edgeCnt == ({lenLat, 1'b0} - CNT_W'(1)));

    stb.idle    = (state == ST_IDLE);
    stb.load    = (state == ST_IDLE) && start;
    stb.toggle  = inShift && tick;
    stb.capture = inShift && tick && (phaseLat ? ~leadingEdge : leadingEdge);
    stb.shift   = inShift && tick &&
                  (phaseLat ? (leadingEdge && !firstEdge) : (!leadingEdge && !lastEdge));
    stb.finish  = (state == ST_TRAIL) && tick && (gapLeft == '0);
    busy        = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      hpLat    <= DIV_W'(1);
      gapLeft  <= '0;
      trailLat <= '0;
      edgeCnt  <= '0;
      lenLat   <= '0;
      phaseLat <= 1'b0;
    end else begin
      if (state == ST_IDLE || tick) divCnt <= '0;
      else                          divCnt <= divCnt + DIV_W'(1);

      unique case (state)
        ST_IDLE: begin
          if (start) begin
            hpLat    <= halfPeriod;
            lenLat   <= wordLen;
            phaseLat <= cpha;
            trailLat <= trailHalves;
            edgeCnt  <= '0;
            gapLeft  <= leadHalves;
            state    <= (leadHalves == '0) ? ST_SHIFT : ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            gapLeft <= gapLeft - GAP_W'(1);
            if (gapLeft == GAP_W'(1)) state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            edgeCnt <= edgeCnt + CNT_W'(1);
            if (lastEdge) begin
              state   <= ST_TRAIL;
              gapLeft <= trailLat;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (gapLeft == '0) state <= ST_IDLE;
            else               gapLeft <= gapLeft - GAP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_master_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  spiStrobe_t          stb,
  input  logic                cpol,
  input  logic                lsbFirst,
  input  logic                csActiveHigh,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                csOut,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                done
);

  localparam int IDX_W = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] txSh;
  logic [MAX_BITS-1:0] txOrd;
  logic [MAX_BITS-1:0] rxCol;
  logic [MAX_BITS-1:0] rxAsm;
  logic [IDX_W-1:0]    rxIdx;
  logic [LEN_W-1:0]    lenLat;
  logic                lsbLat;
  logic                csHiLat;
  logic                sclkR;
  logic                csR;

  // Put bits into send order (bit 0 first) and rebuild the received word.
  for (genvar i = 0; i < MAX_BITS; i++) begin : g_order
    assign txOrd[i] = (LEN_W'(i) < wordLen)
                    ? (lsbFirst ? txWord[i] : txWord[IDX_W'(wordLen - LEN_W'(i + 1))])
                    : 1'b0;
    assign rxAsm[i] = (LEN_W'(i) < lenLat)
                    ? (lsbLat ? rxCol[i] : rxCol[IDX_W'(lenLat - LEN_W'(i + 1))])
                    : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkR   <= 1'b0;
      csR     <= 1'b1;
      txSh    <= '0;
      rxCol   <= '0;
      rxIdx   <= '0;
      rxWord  <= '0;
      done    <= 1'b0;
      lenLat  <= '0;
      lsbLat  <= 1'b0;
      csHiLat <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        lenLat  <= wordLen;
        lsbLat  <= lsbFirst;
        csHiLat <= csActiveHigh;
        txSh    <= txOrd;
        rxCol   <= '0;
        rxIdx   <= '0;
        sclkR   <= cpol;
        csR     <= csActiveHigh;
      end else if (stb.idle) begin
        sclkR <= cpol;
        csR   <= ~csActiveHigh;
      end else begin
        if (stb.toggle) sclkR <= ~sclkR;
        if (stb.shift)  txSh  <= txSh >> 1;
        if (stb.capture) begin
          rxCol[rxIdx] <= miso;
          rxIdx        <= rxIdx + IDX_W'(1);
        end
        if (stb.finish) begin
          csR    <= ~csHiLat;
          rxWord <= rxAsm;
        end
      end
    end
  end

  assign sclk  = sclkR;
  assign csOut = csR;
  assign mosi  = txSh[0];

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_master_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int DIV_W    = 8,
  parameter int GAP_W    = 4,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic [1:0]          spiMode,
  input  logic                lsbFirst,
  input  logic                csActiveHigh,
  input  logic [GAP_W-1:0]    leadHalves,
  input  logic [GAP_W-1:0]    trailHalves,
  input  logic [DIV_W-1:0]    halfPeriod,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                csOut,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                done,
  output logic                busy
);

  spiStrobe_t stb;

  spi_edge_ctrl #(
    .LEN_W(LEN_W),
    .DIV_W(DIV_W),
    .GAP_W(GAP_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cpha       (spiMode[0]),
    .wordLen    (wordLen),
    .leadHalves (leadHalves),
    .trailHalves(trailHalves),
    .halfPeriod (halfPeriod),
    .stb        (stb),
    .busy       (busy)
  );

  spi_shift_path #(
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cpol        (spiMode[1]),
    .lsbFirst    (lsbFirst),
    .csActiveHigh(csActiveHigh),
    .wordLen     (wordLen),
    .txWord      (txWord),
    .miso        (miso),
    .sclk        (sclk),
    .mosi        (mosi),
    .csOut       (csOut),
    .rxWord      (rxWord),
    .done        (done)
  );

endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk #(
  parameter int MAX_BITS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [1:0]          spiMode,
  input logic                csActiveHigh,
  input logic                sclk,
  input logic                csOut,
  input logic [MAX_BITS-1:0] rxWord,
  input logic                done,
  input logic                busy
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: idle clock level tracks polarity
  a_r1_idle_sclk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(busy)) |-> (sclk == $past(spiMode[1])));

  // R6: idle chip select sits at the inactive level
  a_r6_idle_cs: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(busy) && !$past(start)) |-> (csOut == !$past(csActiveHigh)));

  // R6: chip select does not move during a transfer
  a_r6_cs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csOut));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: completion only ends a running transfer
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R9: result only changes with completion
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !done) |-> $stable(rxWord));

endmodule

bind spi_word_master spi_master_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .spiMode     (spiMode),
  .csActiveHigh(csActiveHigh),
  .sclk        (sclk),
  .csOut       (csOut),
  .rxWord      (rxWord),
  .done        (done),
  .busy        (busy)
);

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;

  localparam int MAX_BITS = 32;
  localparam int LEN_W    = 6;
  localparam int DIV_W    = 8;
  localparam int GAP_W    = 4;
  localparam int NVEC     = 8;

  typedef struct packed {
    logic [1:0]  mode;
    logic [5:0]  len;
    logic        lsb;
    logic        csHi;
    logic [3:0]  lead;
    logic [3:0]  trail;
    logic [7:0]  hp;
    logic [31:0] tx;
    logic [31:0] sl;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    {2'd0, 6'd8,  1'b0, 1'b0, 4'd0,  4'd0,  8'd1, 32'h0000FFA5, 32'h0000003C},
    {2'd1, 6'd8,  1'b1, 1'b0, 4'd2,  4'd1,  8'd2, 32'h00000081, 32'h0000007E},
    {2'd2, 6'd16, 1'b0, 1'b1, 4'd1,  4'd3,  8'd1, 32'h0000BEEF, 32'h00001234},
    {2'd3, 6'd12, 1'b1, 1'b1, 4'd15, 4'd15, 8'd3, 32'h00000ABC, 32'h000005A5},
    {2'd0, 6'd32, 1'b1, 1'b0, 4'd3,  4'd0,  8'd2, 32'hDEADBEEF, 32'h0F1E2D3C},
    {2'd1, 6'd4,  1'b0, 1'b0, 4'd0,  4'd2,  8'd1, 32'hFFFFFFF9, 32'h00000006},
    {2'd2, 6'd5,  1'b1, 1'b0, 4'd0,  4'd0,  8'd4, 32'h0000001B, 32'h0000000E},
    {2'd3, 6'd32, 1'b0, 1'b0, 4'd5,  4'd4,  8'd1, 32'h80000001, 32'hFFFF0000}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [MAX_BITS-1:0] txWord = '0;
  logic [LEN_W-1:0]    wordLen = 6'd8;
  logic [1:0]          spiMode = 2'd0;
  logic                lsbFirst = 1'b0;
  logic                csActiveHigh = 1'b0;
  logic [GAP_W-1:0]    leadHalves = '0;
  logic [GAP_W-1:0]    trailHalves = '0;
  logic [DIV_W-1:0]    halfPeriod = 8'd1;
  logic                miso = 1'b0;
  logic                sclk;
  logic                mosi;
  logic                csOut;
  logic [MAX_BITS-1:0] rxWord;
  logic                done;
  logic                busy;

  always #2 clk = ~clk;

  spi_word_master u0 (
    .clk(clk), .rstN(rstN), .start(start), .txWord(txWord), .wordLen(wordLen),
    .spiMode(spiMode), .lsbFirst(lsbFirst), .csActiveHigh(csActiveHigh),
    .leadHalves(leadHalves), .trailHalves(trailHalves), .halfPeriod(halfPeriod),
    .miso(miso), .sclk(sclk), .mosi(mosi), .csOut(csOut), .rxWord(rxWord),
    .done(done), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lenMask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  // Peripheral model settings
  logic        curPhase = 1'b0;
  int          curLen   = 8;
  logic        curLsb   = 1'b0;
  logic        curCsHi  = 1'b0;
  logic [31:0] curSlave = '0;

  function automatic logic slaveBit(input int k);
    return curLsb ? curSlave[k] : curSlave[curLen - 1 - k];
  endfunction

  // Peripheral model and timing monitor
  int          cyc = 0, assertCyc = 0, relCyc = 0, firstCyc = 0, lastCyc = 0, gapCyc = 0;
  int          edges = 0, sendIdx = 0, rcvIdx = 0, doneCnt = 0;
  logic [31:0] slaveGot = '0;
  logic        prevAct = 1'b0, prevSclk = 1'b0;

  always @(negedge clk) begin
    logic csAct;
    logic lead;
    cyc++;
    csAct = (csOut === curCsHi);
    if (done === 1'b1) doneCnt++;
    if (csAct && !prevAct) begin
      gapCyc    = cyc - relCyc;
      assertCyc = cyc;
      edges = 0; sendIdx = 0; rcvIdx = 0; slaveGot = '0;
      if (!curPhase) begin
        miso    = slaveBit(0);
        sendIdx = 1;
      end
    end else if (csAct && (sclk !== prevSclk)) begin
      edges++;
      if (edges == 1) firstCyc = cyc;
      lastCyc = cyc;
      lead = edges[0];
      if ((curPhase == 1'b0) == lead) begin
        if (rcvIdx < curLen) slaveGot[curLsb ? rcvIdx : curLen - 1 - rcvIdx] = mosi;
        rcvIdx++;
      end else begin
        if (sendIdx < curLen) miso = slaveBit(sendIdx);
        sendIdx++;
      end
    end
    if (!csAct && prevAct) relCyc = cyc;
    prevAct  = csAct;
    prevSclk = sclk;
  end

  task automatic applyCfg(input vec_t v);
    @(negedge clk);
    spiMode = v.mode; wordLen = v.len; lsbFirst = v.lsb; csActiveHigh = v.csHi;
    leadHalves = v.lead; trailHalves = v.trail; halfPeriod = v.hp;
    curPhase = v.mode[0]; curLen = int'(v.len); curLsb = v.lsb; curCsHi = v.csHi;
    curSlave = v.sl;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseStart(input logic [31:0] tx);
    start = 1'b1; txWord = tx;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (done !== 1'b1) begin
      if (n > 20000) begin
        fails++; checks++;
        $display("FAIL R9 watchdog: actual no done expected done");
        break;
      end
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int dc;
    logic [31:0] firstGot;
    logic [31:0] firstRx;

    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 sclk", 32'(sclk), 32'd0);
    chk("R12 csOut", 32'(csOut), 32'd1);
    chk("R12 busy", 32'(busy), 32'd0);
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 rxWord", rxWord, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table of transfers
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      applyCfg(v);
      dc = doneCnt;
      @(negedge clk);
      pulseStart(v.tx);
      chk("R6 active level", 32'(csOut), 32'(v.csHi));
      waitDone();
      @(negedge clk);
      chk("R4 R5 rxWord", rxWord, v.sl & lenMask(int'(v.len)));
      if (v.mode[0]) chk("R3 R5 mosi word", slaveGot, v.tx & lenMask(int'(v.len)));
      else           chk("R2 R5 mosi word", slaveGot, v.tx & lenMask(int'(v.len)));
      chk("R4 edge count", 32'(edges), 32'(2 * int'(v.len)));
      chk("R7 lead gap", 32'(firstCyc - assertCyc), 32'((int'(v.lead) + 1) * int'(v.hp)));
      chk("R8 trail gap", 32'(relCyc - lastCyc), 32'((int'(v.trail) + 1) * int'(v.hp)));
      chk("R9 one done", 32'(doneCnt - dc), 32'd1);
      chk("R9 busy low", 32'(busy), 32'd0);
      chk("R1 idle sclk", 32'(sclk), 32'(v.mode[1]));
      chk("R6 idle level", 32'(csOut), 32'(!v.csHi));
    end

    // R10: start during a transfer is ignored
    applyCfg({2'd0, 6'd16, 1'b0, 1'b0, 4'd2, 4'd2, 8'd2, 32'h0, 32'h00001357});
    dc = doneCnt;
    @(negedge clk);
    pulseStart(32'h0000AAAA);
    repeat (10) @(negedge clk);
    pulseStart(32'h00005555);
    waitDone();
    @(negedge clk);
    chk("R10 word kept", slaveGot, 32'h0000AAAA);
    chk("R10 rx", rxWord, 32'h00001357);
    repeat (80) @(negedge clk);
    chk("R10 no extra transfer", 32'(doneCnt - dc), 32'd1);
    chk("R10 idle", 32'(busy), 32'd0);

    // R11: back-to-back words
    applyCfg({2'd1, 6'd8, 1'b0, 1'b0, 4'd0, 4'd0, 8'd1, 32'h0, 32'h000000C3});
    @(negedge clk);
    pulseStart(32'h0000003C);
    waitDone();
    firstRx  = rxWord;
    firstGot = slaveGot;
    curSlave = 32'h00000071;
    pulseStart(32'h00000096);
    waitDone();
    @(negedge clk);
    chk("R11 first rx", firstRx, 32'h000000C3);
    chk("R11 first tx", firstGot, 32'h0000003C);
    chk("R11 second rx", rxWord, 32'h00000071);
    chk("R11 second tx", slaveGot, 32'h00000096);
    chk("R11 cs gap", 32'(gapCyc), 32'd1);

    // R1 and R6: idle levels follow settings
    spiMode = 2'b10;
    repeat (2) @(negedge clk);
    chk("R1 idle high", 32'(sclk), 32'd1);
    spiMode = 2'b00;
    repeat (2) @(negedge clk);
    chk("R1 idle low", 32'(sclk), 32'd0);
    csActiveHigh = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 idle inactive high-mode", 32'(csOut), 32'd0);
    csActiveHigh = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 idle inactive low-mode", 32'(csOut), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule